// File: doc/BRIEF.md
# Processor-Local Interrupt Controller with Selectable Status Semantics

The block gathers the peripheral interrupt lines of one processor core and raises a single registered interrupt request towards it. Software sees two registers through a one-cycle write strobe and a combinational read port. One is a mask register that enables sources; the other is a status register that records which sources are pending. Every input passes through a two-flop synchroniser before any other logic sees it.

A build-time parameter picks the meaning of the status register. In the level variant, status mirrors the synchronised lines and ignores writes. In the edge variant, a rising edge latches a bit, and writing 1 to that bit clears it. In the legacy variant, a high line latches a bit, and writing 0 to that bit clears it. For the software dispatch loop, the block also reports the lowest-numbered source that is both pending and enabled.

Each status bit is a two-state machine (`SL_IDLE`, `SL_HELD`). The `SL_IDLE -> SL_HELD` transition is taken on a set event. The `SL_HELD -> SL_IDLE` transition is taken on a clear request when no set event occurs in the same cycle. The variant decides what counts as a set event and what counts as a clear request:

| Variant | Set event | Clear request |
|---|---|---|
| Level | the line is high | the line is low |
| Edge | a rising edge | writing 1 to the bit |
| Legacy | the line is high | writing 0 to the bit |

Top module: `irq_ctl_top`

## Requirements
- R1: After reset, the mask register (`reg_sel_i`=0) and the status register (`reg_sel_i`=1) both read as zero, `cpu_irq_o` is low, and `pend_vld_o` is low.
- R2: A mask write (`reg_we_i`=1, `reg_sel_i`=0) replaces all 32 mask bits at once. A mask bit of 1 enables its source, and the mask changes only through such a write.
- R3: A change on an input line reaches the status register at the third rising clock edge after the change: two synchroniser flops, then the status flop.
- R4: In the level variant, status bit i equals the delayed line i, and a status write has no effect on it.
- R5: In the edge variant, a rising edge on a line sets its status bit. Writing 1 to the bit clears it, writing 0 leaves it unchanged, and a line that stays high does not set the bit again after a clear.
- R6: In the legacy variant, a high line sets its status bit. Writing 0 to the bit clears it only when the line is low, and writing 1 leaves the bit unchanged.
- R7: In the latched variants, when a set event and a clear request hit the same bit in the same cycle, the bit ends up set.
- R8: A disabled source still latches its status bit, and it raises the interrupt once its mask bit is set.
- R9: `cpu_irq_o` is registered. It equals the OR of (status AND mask) as it stood one clock earlier.
- R10: `pend_idx_o` gives the lowest index i for which status and mask bit i are both set, and `pend_vld_o` is then 1. When no such bit exists, both outputs are 0.
- R11: After a mask-then-acknowledge sequence (clear the mask bit, then clear the status bit with the variant's polarity), the source no longer shows in `pend_idx_o` or `cpu_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Peripheral interrupt lines, asynchronous |
| reg_we_i | input | 1 | One-cycle register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = mask, 1 = status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| cpu_irq_o | output | 1 | Registered interrupt request to the core |
| pend_idx_o | output | 5 | Lowest pending and enabled source index |
| pend_vld_o | output | 1 | `pend_idx_o` is meaningful |

## Verification
The hardest situation to create is a status clear that lands in exactly the cycle in which the same bit sees a fresh rising edge. Because of the synchroniser, the edge becomes visible two edges after the line changes. The stimulus therefore raises a line on a falling edge, counts two rising edges, and only then asserts the status-write strobe with a 1 in that bit. The set event and the clear request then meet at the third edge. All three variants run side by side on the same stimulus, so every write is also seen with the other two clear polarities.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    typedef enum logic [1:0] {
        VAR_LEVEL  = 2'd0,
        VAR_EDGE   = 2'd1,
        VAR_LEGACY = 2'd2
    } irq_variant_e;

    typedef enum logic {
        SL_IDLE = 1'b0,
        SL_HELD = 1'b1
    } latch_state_e;

    localparam logic REG_MASK   = 1'b0;
    localparam logic REG_STATUS = 1'b1;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/irq_status_cell.sv
module irq_status_cell
    import irq_ctl_pkg::*;
#(
    parameter irq_variant_e VARIANT = VAR_EDGE
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    input  logic stat_wr_i,
    input  logic wbit_i,
    output logic set_o,
    output logic stat_o
);
    latch_state_e state_q, state_d;
    logic         prev_q;
    logic         set_ev;
    logic         clr_req;

    // Event decode per variant
    always_comb begin
        unique case (VARIANT)
            VAR_LEVEL: begin
                set_ev  = line_i;
                clr_req = ~line_i;
            end
            VAR_EDGE: begin
                set_ev  = line_i & ~prev_q;
                clr_req = stat_wr_i & wbit_i;
            end
            default: begin
                set_ev  = line_i;
                clr_req = stat_wr_i & ~wbit_i;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SL_IDLE;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= line_i;
        end
    end

    // Next state: set beats clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_IDLE: if (set_ev)             state_d = SL_HELD;
            SL_HELD: if (clr_req && !set_ev) state_d = SL_IDLE;
            default:                         state_d = SL_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        stat_o = (state_q == SL_HELD);
        set_o  = set_ev;
    end
endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          vld_o
);
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
                vld_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
#(
    parameter int           N_SRC   = 32,
    parameter irq_variant_e VARIANT = VAR_EDGE
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [N_SRC-1:0]         irq_src_i,
    input  logic                     reg_we_i,
    input  logic                     reg_sel_i,
    input  logic [N_SRC-1:0]         reg_wdata_i,
    output logic [N_SRC-1:0]         reg_rdata_o,
    output logic                     cpu_irq_o,
    output logic [$clog2(N_SRC)-1:0] pend_idx_o,
    output logic                     pend_vld_o
);
    localparam int IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0] line_w;
    logic [N_SRC-1:0] status_w;
    logic [N_SRC-1:0] set_w;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] active_w;
    logic             irq_q;
    logic             stat_wr;

    irq_sync #(.W(N_SRC)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (irq_src_i),
        .sync_o  (line_w)
    );

    assign stat_wr = reg_we_i && (reg_sel_i == REG_STATUS);

    for (genvar g = 0; g < N_SRC; g++) begin : g_cell
        irq_status_cell #(.VARIANT(VARIANT)) u_cell (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .line_i    (line_w[g]),
            .stat_wr_i (stat_wr),
            .wbit_i    (reg_wdata_i[g]),
            .set_o     (set_w[g]),
            .stat_o    (status_w[g])
        );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (reg_we_i && (reg_sel_i == REG_MASK)) mask_q <= reg_wdata_i;
            irq_q <= |active_w;
        end
    end

    assign active_w = status_w & mask_q;

    irq_lowest #(.N(N_SRC), .IW(IDX_W)) u_lowest (
        .vec_i (active_w),
        .idx_o (pend_idx_o),
        .vld_o (pend_vld_o)
    );

    always_comb begin
        reg_rdata_o = (reg_sel_i == REG_STATUS) ? status_w : mask_q;
        cpu_irq_o   = irq_q;
    end
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
    import irq_ctl_pkg::*;
#(
    parameter int           N_SRC   = 32,
    parameter irq_variant_e VARIANT = VAR_EDGE
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     reg_we_i,
    input logic                     reg_sel_i,
    input logic [N_SRC-1:0]         mask_q,
    input logic [N_SRC-1:0]         status_w,
    input logic [N_SRC-1:0]         set_w,
    input logic                     cpu_irq_o,
    input logic [$clog2(N_SRC)-1:0] pend_idx_o,
    input logic                     pend_vld_o
);
    localparam bit LATCHED = (VARIANT != VAR_LEVEL);

    logic [N_SRC-1:0] pend_vec;
    logic [N_SRC-1:0] below;
    logic             stat_wr;

    assign pend_vec = status_w & mask_q;
    assign below    = (N_SRC'(1) << pend_idx_o) - N_SRC'(1);
    assign stat_wr  = reg_we_i && (reg_sel_i == REG_STATUS);

    AST_MASK_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_q != $past(mask_q)) |-> $past(reg_we_i && reg_sel_i == REG_MASK)); // R2
    AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (LATCHED && !stat_wr) |=> ((status_w & $past(status_w)) == $past(status_w))); // R5
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (LATCHED && set_w != '0) |=> ((status_w & $past(set_w)) == $past(set_w))); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_vec == '0) |=> !cpu_irq_o); // R9
    AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_vec != '0) |=> cpu_irq_o); // R9
    AST_PEND_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_vld_o |-> (pend_vec[pend_idx_o] && ((pend_vec & below) == '0))); // R10
    AST_PEND_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_vld_o |-> (pend_vec == '0 && pend_idx_o == '0)); // R10
endmodule

bind irq_ctl_top irq_ctl_chk #(.N_SRC(N_SRC), .VARIANT(VARIANT)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_sel_i  (reg_sel_i),
    .mask_q     (mask_q),
    .status_w   (status_w),
    .set_w      (set_w),
    .cpu_irq_o  (cpu_irq_o),
    .pend_idx_o (pend_idx_o),
    .pend_vld_o (pend_vld_o)
);

// File: tb/test_irq_ctl_top.sv
module test_irq_ctl_top;
    import irq_ctl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        we = 1'b0;
    logic        sel = 1'b0;
    logic [31:0] wdata = '0;

    // index 0 = edge, 1 = level, 2 = legacy
    logic [31:0] rd_w  [3];
    logic        irq_w [3];
    logic [4:0]  idx_w [3];
    logic        vld_w [3];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          dut;
        int          kind;   // 0 rdata, 1 irq, 2 {vld,idx}
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    irq_ctl_top #(.N_SRC(32), .VARIANT(VAR_EDGE)) i_irq_ctl_top (
        .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .reg_we_i(we),
        .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rd_w[0]),
        .cpu_irq_o(irq_w[0]), .pend_idx_o(idx_w[0]), .pend_vld_o(vld_w[0]));
    irq_ctl_top #(.N_SRC(32), .VARIANT(VAR_LEVEL)) i_irq_ctl_top_lvl (
        .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .reg_we_i(we),
        .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rd_w[1]),
        .cpu_irq_o(irq_w[1]), .pend_idx_o(idx_w[1]), .pend_vld_o(vld_w[1]));
    irq_ctl_top #(.N_SRC(32), .VARIANT(VAR_LEGACY)) i_irq_ctl_top_leg (
        .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .reg_we_i(we),
        .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rd_w[2]),
        .cpu_irq_o(irq_w[2]), .pend_idx_o(idx_w[2]), .pend_vld_o(vld_w[2]));

    function automatic logic [31:0] pv(bit v, int i);
        return v ? (32'h100 | 32'(i)) : 32'h0;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic s, logic [31:0] d);
        @(negedge clk); we = 1'b1; sel = s; wdata = d;
        @(negedge clk); we = 1'b0; wdata = '0;
    endtask

    task automatic look(logic s);
        @(negedge clk); sel = s; #1;
    endtask

    task automatic exp3(int kind, logic [31:0] e0, logic [31:0] e1,
                        logic [31:0] e2, string tag);
        sb.push_back('{0, kind, e0, tag});
        sb.push_back('{1, kind, e1, tag});
        sb.push_back('{2, kind, e2, tag});
    endtask

    // Monitor: compares queued expectations with the ports
    initial begin
        forever begin
            @(negedge clk); #3;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = rd_w[it.dut];
                    1:       act = 32'(irq_w[it.dut]);
                    default: act = vld_w[it.dut] ? (32'h100 | 32'(idx_w[it.dut]))
                                                 : 32'(idx_w[it.dut]);
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s dut%0d kind%0d actual=%h expected=%h",
                             it.tag, it.dut, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;

        // R1 reset state
        look(0); exp3(0, 0, 0, 0, "R1 mask reset");
        look(1); exp3(0, 0, 0, 0, "R1 status reset");
        exp3(1, 0, 0, 0, "R1 irq reset"); exp3(2, 0, 0, 0, "R1 R10 no pending");

        // R2 mask write
        wr(0, 32'h0000_00FF);
        look(0); exp3(0, 32'hFF, 32'hFF, 32'hFF, "R2 mask readback");

        // R3 latency, R9 irq registered
        @(negedge clk); src[3] = 1'b1;
        look(1); exp3(0, 0, 0, 0, "R3 edge1");
        look(1); exp3(0, 0, 0, 0, "R3 edge2");
        look(1); exp3(0, 8, 8, 8, "R3 edge3"); exp3(1, 0, 0, 0, "R9 not yet");
        look(1); exp3(1, 1, 1, 1, "R9 irq up"); exp3(2, pv(1,3), pv(1,3), pv(1,3), "R10 idx3");

        // line drops: level follows, latched hold
        @(negedge clk); src[3] = 1'b0;
        step(4);
        look(1); exp3(0, 8, 0, 8, "R4 R5 R6 after drop"); exp3(1, 1, 0, 1, "R9 after drop");
        wr(1, 32'h0);
        look(1); exp3(0, 8, 0, 0, "R5 R6 write zero");
        wr(1, 32'hFFFF_FFFF);
        look(1); exp3(0, 0, 0, 0, "R5 write one"); exp3(1, 0, 0, 0, "R9 irq down");

        // held line: clear polarity and no re-set
        @(negedge clk); src[5] = 1'b1;
        step(4);
        look(1); exp3(0, 32'h20, 32'h20, 32'h20, "R3 held");
        wr(1, 32'h0);
        look(1); exp3(0, 32'h20, 32'h20, 32'h20, "R6 held blocks clear, R4 ignored");
        wr(1, 32'hFFFF_FFFF);
        look(1); exp3(0, 0, 32'h20, 32'h20, "R5 clear while held, R6 write one");
        step(3);
        look(1); exp3(0, 0, 32'h20, 32'h20, "R5 no re-set while held");
        @(negedge clk); src[5] = 1'b0;
        step(4); wr(1, 32'h0);
        look(1); exp3(0, 0, 0, 0, "R6 clear after low");

        // R7 set and clear in the same cycle
        @(negedge clk); src[7] = 1'b1;
        @(negedge clk);
        @(negedge clk); we = 1'b1; sel = 1'b1; wdata = 32'h80;
        @(negedge clk); we = 1'b0; wdata = '0;
        look(1); exp3(0, 32'h80, 32'h80, 32'h80, "R7 set wins");
        @(negedge clk); src[7] = 1'b0;
        step(4); wr(1, 32'hFFFF_FFFF); wr(1, 32'h0);
        look(1); exp3(0, 0, 0, 0, "R7 cleanup");

        // R8 masked source latches, taken when enabled
        @(negedge clk); src[20] = 1'b1;
        step(4);
        @(negedge clk); src[20] = 1'b0;
        step(4);
        look(1); exp3(0, 32'h10_0000, 0, 32'h10_0000, "R8 masked latch");
        exp3(1, 0, 0, 0, "R8 masked no irq"); exp3(2, 0, 0, 0, "R8 R10 masked none");
        wr(0, 32'h0010_00FF);
        look(0); exp3(0, 32'h1000FF, 32'h1000FF, 32'h1000FF, "R2 mask all bits");
        exp3(1, 1, 0, 1, "R8 taken on unmask"); exp3(2, pv(1,20), 0, pv(1,20), "R8 idx20");

        // R10 lowest index wins
        @(negedge clk); src[2] = 1'b1; src[6] = 1'b1;
        step(4);
        look(1); exp3(2, pv(1,2), pv(1,2), pv(1,2), "R10 lowest of 2,6,20");
        exp3(0, 32'h100044, 32'h44, 32'h100044, "R10 status");
        @(negedge clk); src[2] = 1'b0; src[6] = 1'b0;
        step(4);
        look(1); exp3(2, pv(1,2), 0, pv(1,2), "R10 after drop");

        // R11 mask then acknowledge
        wr(0, 32'h0010_00FB);
        look(1); exp3(2, pv(1,6), 0, pv(1,6), "R11 masked skip");
        wr(1, 32'h4);
        look(1); exp3(0, 32'h100040, 0, 32'h4, "R11 ack edge polarity");
        exp3(1, 1, 0, 0, "R11 irq"); exp3(2, pv(1,6), 0, 0, "R11 idx");
        wr(1, 32'h0); wr(1, 32'hFFFF_FFFF);
        look(1); exp3(0, 0, 0, 0, "R11 all acked"); exp3(1, 0, 0, 0, "R11 irq low");
        exp3(2, 0, 0, 0, "R11 none pending");

        step(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule